// File: doc/BRIEF.md
# Dual-Port RAM Port Controller

This block is a synchronous model of a true dual-port static memory. Two ports, left and right, each carry their own address, write data, read data, a read-data-valid flag that stands in for the bus drivers, a read/write select, an output enable, a pair of chip enables of opposite polarity and a semaphore-select input. Either port may read or write any word at any time, including a word the other port is using in the same cycle.

Each port decodes its control pins into one of five access kinds: deselected, semaphore access (left to a separate semaphore block), write, read, or read with outputs muted. Writes land at the clock edge. Reads return the stored word one cycle later, with the valid flag raised in the same cycle. A deselected port raises its standby flag one cycle later. The word count is a parameter, and the address width is derived from it. The default is 64 words of 8 bits, which keeps simulation small. When both ports write the same word in one cycle, the left port's data is kept.

Top module: `dpram_port_ctrl`

## Requirements
- R1: A port is selected only when `cs0_n` is 0 and `cs1` is 1. In every other combination the port neither reads nor writes. One cycle later it shows `standby` = 1 and `rdata_oe` = 0. A selected port shows `standby` = 0 one cycle later.
- R2: A selected port with `sem_n` = 1 and `wr_n` = 0 stores `wdata` at `addr` at the clock edge, whatever the level of `oe_n`. A write shows `rdata_oe` = 0 in the following cycle.
- R3: A selected port with `sem_n` = 1, `wr_n` = 1 and `oe_n` = 0 presents the stored word on `rdata` with `rdata_oe` = 1 in the following cycle.
- R4: A read with `oe_n` = 1 gives `rdata_oe` = 0 in the following cycle. Whenever `rdata_oe` is 0, `rdata` is all zeros.
- R5: A selected port with `sem_n` = 0 leaves the memory untouched and returns no data (`rdata_oe` = 0). It is still counted as selected (`standby` = 0).
- R6: Both ports may read the same word in the same cycle, and both receive it.
- R7: The ports are independent. One port may write while the other reads. A read of the word that the other port writes in that same cycle returns the old contents, and the new contents are visible from the next cycle on.
- R8: During and right after reset, each port shows `rdata_oe` = 0, `rdata` = 0 and `standby` = 1, and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs0_n | input | 1 | Left chip enable, active low |
| l_cs1 | input | 1 | Left chip enable, active high |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_wr_n | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left read data, zero when not valid |
| l_rdata_oe | output | 1 | Left read data valid / bus drive enable |
| l_standby | output | 1 | Left port deselected status |
| r_cs0_n | input | 1 | Right chip enable, active low |
| r_cs1 | input | 1 | Right chip enable, active high |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_wr_n | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right read data, zero when not valid |
| r_rdata_oe | output | 1 | Right read data valid / bus drive enable |
| r_standby | output | 1 | Right port deselected status |

## Verification
Every output of this block is due exactly one clock edge after the control pins that cause it: read data, its valid flag and the standby flag are all registered once. A write becomes visible to a read issued on the following cycle. The bench therefore changes inputs on a falling edge and checks the results on the next falling edge, so exactly one rising edge lies between stimulus and check. For cross-port cases it reads the other port's result in that same half-cycle window. Each later read-back is a separate step, so it observes what the earlier write left in memory.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Access kind decoded per port from its control pins
    typedef enum logic [2:0] {
        ACC_OFF   = 3'd0,  // port deselected
        ACC_SEM   = 3'd1,  // semaphore space, not the memory
        ACC_WRITE = 3'd2,
        ACC_READ  = 3'd3,
        ACC_MUTE  = 3'd4   // read with outputs disabled
    } acc_e;

endpackage

// File: rtl/dpram_mode_dec.sv
module dpram_mode_dec
    import dpram_pkg::*;
(
    input  logic cs0_n,
    input  logic cs1,
    input  logic sem_n,
    input  logic wr_n,
    input  logic oe_n,
    output acc_e acc
);

    logic sel;

    always_comb begin
        sel = ~cs0_n & cs1;
        if (!sel)       acc = ACC_OFF;
        else if (!sem_n) acc = ACC_SEM;
        else if (!wr_n)  acc = ACC_WRITE;
        else if (!oe_n)  acc = ACC_READ;
        else             acc = ACC_MUTE;
    end

endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int NP    = 2,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  addr,
    input  logic [NP-1:0][DW-1:0]  wdata,
    output logic [NP-1:0][DW-1:0]  rword
);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    // Port 0 is applied last, so it wins a same-word collision
    always_comb begin
        mem_d = mem_q;
        for (int p = NP - 1; p >= 0; p--) begin
            if (we[p]) mem_d[addr[p]] = wdata[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    // Old contents seen by reads; the output stage registers them
    generate
        for (genvar g = 0; g < NP; g++) begin : g_rd
            assign rword[g] = mem_q[addr[g]];
        end
    endgenerate

endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
    import dpram_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_e          acc,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    output logic          standby
);

    typedef struct packed {
        logic          standby;
        logic          oe;
        logic [DW-1:0] data;
    } out_t;

    localparam out_t OUT_RST = '{standby: 1'b1, oe: 1'b0, data: '0};

    out_t st_d, st_q;

    always_comb begin
        st_d         = OUT_RST;
        st_d.standby = (acc == ACC_OFF);
        if (acc == ACC_READ) begin
            st_d.oe   = 1'b1;
            st_d.data = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OUT_RST;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.data;
    assign rdata_oe = st_q.oe;
    assign standby  = st_q.standby;

endmodule

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
    import dpram_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_cs0_n,
    input  logic          l_cs1,
    input  logic          l_sem_n,
    input  logic          l_wr_n,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rdata_oe,
    output logic          l_standby,
    input  logic          r_cs0_n,
    input  logic          r_cs1,
    input  logic          r_sem_n,
    input  logic          r_wr_n,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rdata_oe,
    output logic          r_standby
);

    localparam int NP = 2;  // index 0 = left, 1 = right

    logic [NP-1:0]         cs0_n_v, cs1_v, sem_n_v, wr_n_v, oe_n_v;
    logic [NP-1:0][AW-1:0] addr_v;
    logic [NP-1:0][DW-1:0] wdata_v, rword_v, rdata_v;
    logic [NP-1:0]         we_v, oe_v, sb_v;
    acc_e                  acc_v [NP];

    assign cs0_n_v = {r_cs0_n, l_cs0_n};
    assign cs1_v   = {r_cs1,   l_cs1};
    assign sem_n_v = {r_sem_n, l_sem_n};
    assign wr_n_v  = {r_wr_n,  l_wr_n};
    assign oe_n_v  = {r_oe_n,  l_oe_n};
    assign addr_v  = {r_addr,  l_addr};
    assign wdata_v = {r_wdata, l_wdata};

    generate
        for (genvar g = 0; g < NP; g++) begin : g_port
            dpram_mode_dec i_dec (
                .cs0_n (cs0_n_v[g]),
                .cs1   (cs1_v[g]),
                .sem_n (sem_n_v[g]),
                .wr_n  (wr_n_v[g]),
                .oe_n  (oe_n_v[g]),
                .acc   (acc_v[g])
            );

            assign we_v[g] = (acc_v[g] == ACC_WRITE);

            dpram_port_out #(.DW(DW)) i_out (
                .clk      (clk),
                .rst_n    (rst_n),
                .acc      (acc_v[g]),
                .word     (rword_v[g]),
                .rdata    (rdata_v[g]),
                .rdata_oe (oe_v[g]),
                .standby  (sb_v[g])
            );
        end
    endgenerate

    dpram_array #(.DW(DW), .DEPTH(DEPTH), .NP(NP), .AW(AW)) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_v),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rword (rword_v)
    );

    assign l_rdata    = rdata_v[0];
    assign l_rdata_oe = oe_v[0];
    assign l_standby  = sb_v[0];
    assign r_rdata    = rdata_v[1];
    assign r_rdata_oe = oe_v[1];
    assign r_standby  = sb_v[1];

endmodule

// File: rtl/dpram_chk.sv
module dpram_chk #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_cs0_n,
    input logic          l_cs1,
    input logic          l_sem_n,
    input logic          l_wr_n,
    input logic          l_oe_n,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_wdata,
    input logic [DW-1:0] l_rdata,
    input logic          l_rdata_oe,
    input logic          l_standby,
    input logic          r_cs0_n,
    input logic          r_cs1,
    input logic          r_sem_n,
    input logic          r_wr_n,
    input logic          r_oe_n,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_rdata,
    input logic          r_rdata_oe,
    input logic          r_standby
);

    logic l_sel, r_sel, l_wr, l_rd, r_wr, r_rd;
    logic [1:0] age_q;

    assign l_sel = ~l_cs0_n & l_cs1;
    assign r_sel = ~r_cs0_n & r_cs1;
    assign l_wr  = l_sel & l_sem_n & ~l_wr_n;
    assign l_rd  = l_sel & l_sem_n & l_wr_n & ~l_oe_n;
    assign r_wr  = r_sel & r_sem_n & ~r_wr_n;
    assign r_rd  = r_sel & r_sem_n & r_wr_n & ~r_oe_n;

    // cycles since reset, saturating, so $past never reaches into reset
    always_ff @(posedge clk) begin
        if (!rst_n)         age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_desel_left_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !l_sel |=> (l_standby && !l_rdata_oe));
    assert_desel_right_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !r_sel |=> (r_standby && !r_rdata_oe));

    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(l_rd) && $past(l_wr, 2) &&
         $past(l_addr) == $past(l_addr, 2) &&
         !($past(r_wr, 2) && $past(r_addr, 2) == $past(l_addr, 2)))
        |-> (l_rdata == $past(l_wdata, 2)));

    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |=> l_rdata_oe);
    assert_read_valid_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd |=> r_rdata_oe);

    assert_mute_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_sem_n && l_wr_n && l_oe_n) |=> !l_rdata_oe);
    assert_zero_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_rdata_oe |-> l_rdata == '0) and (!r_rdata_oe |-> r_rdata == '0));

    assert_sem_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && !l_sem_n) |=> (!l_rdata_oe && !l_standby));

    assert_shared_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd && r_rd && l_addr == r_addr) |=> (l_rdata == r_rdata));

endmodule

bind dpram_port_ctrl dpram_chk #(.DW(DW), .AW(AW)) i_chk (.*);

// File: tb/test_dpram_port_ctrl.sv
`timescale 1ns/100ps
module test_dpram_port_ctrl;

    localparam int DW = 8;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int NV = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_cs0_n, l_cs1, l_sem_n, l_wr_n, l_oe_n;
    logic r_cs0_n, r_cs1, r_sem_n, r_wr_n, r_oe_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_rdata_oe, r_rdata_oe, l_standby, r_standby;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dpram_port_ctrl #(.DW(DW), .DEPTH(DEPTH)) i_dpram_port_ctrl (.*);

    // {cs0_n, cs1, sem_n, wr_n, oe_n, addr[6], wdata[8], exp_oe, exp_data[8], exp_sb, req[4]}
    localparam logic [32:0] VEC [NV] = '{
        {5'b01101, 6'd5,  8'hA5, 1'b0, 8'h00, 1'b0, 4'd2}, // R2 write, oe_n high
        {5'b01100, 6'd6,  8'h3C, 1'b0, 8'h00, 1'b0, 4'd2}, // R2 write, oe_n low
        {5'b01110, 6'd5,  8'h00, 1'b1, 8'hA5, 1'b0, 4'd3}, // R3 read back
        {5'b01110, 6'd6,  8'h00, 1'b1, 8'h3C, 1'b0, 4'd3}, // R3 read back
        {5'b01111, 6'd5,  8'h00, 1'b0, 8'h00, 1'b0, 4'd4}, // R4 muted read
        {5'b11101, 6'd5,  8'hFF, 1'b0, 8'h00, 1'b1, 4'd1}, // R1 cs0_n high
        {5'b00101, 6'd5,  8'hFF, 1'b0, 8'h00, 1'b1, 4'd1}, // R1 cs1 low
        {5'b10110, 6'd5,  8'h00, 1'b0, 8'h00, 1'b1, 4'd1}, // R1 both wrong
        {5'b01110, 6'd5,  8'h00, 1'b1, 8'hA5, 1'b0, 4'd1}, // R1 writes dropped
        {5'b01001, 6'd5,  8'h11, 1'b0, 8'h00, 1'b0, 4'd5}, // R5 sem write
        {5'b01010, 6'd5,  8'h00, 1'b0, 8'h00, 1'b0, 4'd5}, // R5 sem read
        {5'b01110, 6'd5,  8'h00, 1'b1, 8'hA5, 1'b0, 4'd5}, // R5 memory intact
        {5'b01110, 6'd7,  8'h00, 1'b1, 8'h00, 1'b0, 4'd8}, // R8 cleared word
        {5'b01101, 6'd63, 8'hC3, 1'b0, 8'h00, 1'b0, 4'd2}, // R2 top word
        {5'b01110, 6'd63, 8'h00, 1'b1, 8'hC3, 1'b0, 4'd3}  // R3 top word
    };

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {oe,data,standby} got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_l(input logic [4:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        {l_cs0_n, l_cs1, l_sem_n, l_wr_n, l_oe_n} = c;
        l_addr = a;
        l_wdata = d;
    endtask

    task automatic drive_r(input logic [4:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
        {r_cs0_n, r_cs1, r_sem_n, r_wr_n, r_oe_n} = c;
        r_addr = a;
        r_wdata = d;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        drive_l(5'b10111, '0, '0);
        drive_r(5'b10111, '0, '0);
        repeat (3) @(negedge clk);
        check("R8 reset left", {l_rdata_oe, l_rdata, l_standby}, {1'b0, 8'h00, 1'b1});
        check("R8 reset right", {r_rdata_oe, r_rdata, r_standby}, {1'b0, 8'h00, 1'b1});
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", {l_rdata_oe, l_rdata, l_standby}, {1'b0, 8'h00, 1'b1});

        for (int i = 0; i < NV; i++) begin
            drive_l(VEC[i][32:28], VEC[i][27:22], VEC[i][21:14]);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i][3:0], i),
                  {l_rdata_oe, l_rdata, l_standby}, VEC[i][13:4]);
        end

        // R6: both ports read word 5 together
        drive_l(5'b01110, 6'd5, 8'h00);
        drive_r(5'b01110, 6'd5, 8'h00);
        @(negedge clk);
        check("R6 left", {l_rdata_oe, l_rdata, l_standby}, {1'b1, 8'hA5, 1'b0});
        check("R6 right", {r_rdata_oe, r_rdata, r_standby}, {1'b1, 8'hA5, 1'b0});

        // R7: right writes word 9 while left reads it -> old contents
        drive_l(5'b01110, 6'd9, 8'h00);
        drive_r(5'b01100, 6'd9, 8'h5A);
        @(negedge clk);
        check("R7 read during write", {l_rdata_oe, l_rdata, l_standby}, {1'b1, 8'h00, 1'b0});
        check("R7 right write", {r_rdata_oe, r_rdata, r_standby}, {1'b0, 8'h00, 1'b0});

        // R7: new contents next cycle; R1: right deselected by cs1 low
        drive_r(5'b00110, 6'd9, 8'h00);
        @(negedge clk);
        check("R7 new word", {l_rdata_oe, l_rdata, l_standby}, {1'b1, 8'h5A, 1'b0});
        check("R1 right deselected", {r_rdata_oe, r_rdata, r_standby}, {1'b0, 8'h00, 1'b1});

        // R7: left writes word 10 while right reads word 6
        drive_l(5'b01101, 6'd10, 8'h77);
        drive_r(5'b01110, 6'd6, 8'h00);
        @(negedge clk);
        check("R7 right read during left write", {r_rdata_oe, r_rdata, r_standby}, {1'b1, 8'h3C, 1'b0});

        // R6: shared read of the word just written by the left port
        drive_l(5'b01110, 6'd10, 8'h00);
        drive_r(5'b01110, 6'd10, 8'h00);
        @(negedge clk);
        check("R6 shared new word left", {l_rdata_oe, l_rdata, l_standby}, {1'b1, 8'h77, 1'b0});
        check("R6 shared new word right", {r_rdata_oe, r_rdata, r_standby}, {1'b1, 8'h77, 1'b0});

        // R4: right muted read
        drive_r(5'b01111, 6'd10, 8'h00);
        @(negedge clk);
        check("R4 right muted", {r_rdata_oe, r_rdata, r_standby}, {1'b0, 8'h00, 1'b0});

        finish_run();
    end

endmodule